// File: doc/BRIEF.md
# Clear-Once Register Access Gate

This block sits between a peripheral's bus port and a small file of eight target registers. It decides for each access whether that access reaches its target. Two 8-bit permission registers hold the decisions, one bit per target. The write-permission register governs stores and the read-permission register governs loads. Every bit comes up as one after system reset. Software can drop a bit to zero, but it cannot raise it again. The only way to restore a bit is another system reset. The block has no other reset input, so a software reset or a battery-domain reset elsewhere in the chip leaves the bits alone.

A store to a target whose write bit is set raises that target's one-cycle write strobe. If the bit is clear, the store is dropped without a strobe. A load from a target whose read bit is set raises the target's read strobe and returns the target's data on the same cycle. If the bit is clear, the load returns zero, raises no strobe and still completes in the same cycle, with no error signal. The two permission registers are always reachable. Their upper 24 bits read as zero.

Top module: `acc_gate`

## Requirements
- R1: After system reset (`rst_ni` low), a read of the write-permission register (offset 0x800) returns 0x0000_00FF, and so does a read of the read-permission register (offset 0x804).
- R2: A write to either permission register sets each bit 7:0 to its old value ANDed with the matching `wdata_i` bit. Writing a one never sets a bit that is already clear.
- R3: Once a permission bit is clear, it stays clear through any bus traffic. Only system reset returns it to one.
- R4: Bits 31:8 of both permission registers always read as zero. Writing to those bits has no effect.
- R5: A write to target i at offset 4*i raises `tgt_we_o[i]` for that cycle only if write-permission bit i is one. If the bit is zero, `tgt_we_o` stays all zero.
- R6: A read of target i whose read-permission bit is one raises `tgt_re_o[i]`. In the same cycle, `rdata_o` carries bits 32*i+31:32*i of `tgt_rdata_i`.
- R7: A read of target i whose read-permission bit is zero returns all zeros on `rdata_o` in the same cycle and leaves `tgt_re_o` all zero.
- R8: Target order and bit order match. Bit/target 0 is time-seconds, 1 time-prescaler, 2 time-alarm, 3 time-compensation, 4 control, 5 status, 6 lock, 7 interrupt-enable.
- R9: The permission registers are readable and writable whatever the state of their own bits, including after all bits are cleared.
- R10: Accesses to any other address, including one with `addr_i[1:0]` nonzero, read zero, raise no strobe and change no permission bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the peripheral |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| tgt_we_o | output | 8 | Per-target write strobe |
| tgt_re_o | output | 8 | Per-target read strobe |
| tgt_wdata_o | output | 32 | Write data forwarded to targets |
| tgt_rdata_i | input | 256 | Target read data, target i in bits 32*i+31:32*i |

## Verification
The bench goes after the one-way nature of the bits. It clears bits and then writes ones back. A design that used a plain store instead of an AND would silently re-enable a target. A design that reset on anything but `rst_ni` would show 0xFF too early. Blocked reads are checked for zero data and a silent `tgt_re_o`; a design that only masked the data would still disturb read-sensitive targets. Misaligned and out-of-window addresses are also driven, where a loose decoder would alias onto a target or onto a permission register.

// File: rtl/acc_gate_pkg.sv
`timescale 1ns/1ps
package acc_gate_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_TGT   = 2'd1,
    RGN_WPERM = 2'd2,
    RGN_RPERM = 2'd3
  } region_e;
endpackage

// File: rtl/acc_gate_decode.sv
`timescale 1ns/1ps
module acc_gate_decode
  import acc_gate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_TGT   = 8,
  parameter int unsigned IDX_W     = 3,
  parameter logic [ADDR_W-1:0] WPERM_OFS = 12'h800,
  parameter logic [ADDR_W-1:0] RPERM_OFS = 12'h804
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] TGT_SPAN = ADDR_W'(NUM_TGT * 4);

  always_comb begin
    region_o = RGN_NONE;
    idx_o    = addr_i[IDX_W+1:2];
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == WPERM_OFS)      region_o = RGN_WPERM;
      else if (addr_i == RPERM_OFS) region_o = RGN_RPERM;
      else if (addr_i < TGT_SPAN)   region_o = RGN_TGT;
    end
  end
endmodule

// File: rtl/acc_gate_perm.sv
`timescale 1ns/1ps
module acc_gate_perm #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] bits_q;
  logic         past_ok_q;

  // only system reset can raise a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bits_q <= '1;
    else if (clr_en_i) bits_q <= bits_q & clr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign bits_o = bits_q;

  p_no_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((bits_o & ~$past(bits_o)) == '0));

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((bits_o & ~$past(clr_data_i)) == '0));
endmodule

// File: rtl/acc_gate_rmux.sv
`timescale 1ns/1ps
module acc_gate_rmux
  import acc_gate_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                      rd_req_i,
  input  region_e                   region_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [NUM_TGT-1:0]        wperm_i,
  input  logic [NUM_TGT-1:0]        rperm_i,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata_i,
  output logic [DATA_W-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_req_i) begin
      unique case (region_i)
        RGN_WPERM: rdata_o = DATA_W'(wperm_i);
        RGN_RPERM: rdata_o = DATA_W'(rperm_i);
        RGN_TGT:   if (rperm_i[idx_i]) rdata_o = tgt_rdata_i[idx_i*DATA_W +: DATA_W];
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/acc_gate.sv
`timescale 1ns/1ps
module acc_gate
  import acc_gate_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_TGT = 8,
  parameter logic [ADDR_W-1:0] WPERM_OFS = 12'h800,
  parameter logic [ADDR_W-1:0] RPERM_OFS = 12'h804
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_TGT-1:0]        tgt_we_o,
  output logic [NUM_TGT-1:0]        tgt_re_o,
  output logic [DATA_W-1:0]         tgt_wdata_o,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata_i
);
  localparam int unsigned IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int unsigned NUM_PERM = 2; // 0: write, 1: read

  region_e            region;
  logic [IDX_W-1:0]   idx;
  logic [NUM_TGT-1:0] perm [NUM_PERM];
  logic [NUM_TGT-1:0] wperm, rperm;

  acc_gate_decode #(
    .ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT), .IDX_W(IDX_W),
    .WPERM_OFS(WPERM_OFS), .RPERM_OFS(RPERM_OFS)
  ) u_decode (
    .addr_i  (addr_i),
    .region_o(region),
    .idx_o   (idx)
  );

  for (genvar g = 0; g < NUM_PERM; g++) begin : g_perm
    localparam region_e MY_RGN = (g == 0) ? RGN_WPERM : RGN_RPERM;
    logic clr_en;
    assign clr_en = req_i && we_i && (region == MY_RGN);
    acc_gate_perm #(.W(NUM_TGT)) u_perm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_en_i  (clr_en),
      .clr_data_i(wdata_i[NUM_TGT-1:0]),
      .bits_o    (perm[g])
    );
  end

  assign wperm = perm[0];
  assign rperm = perm[1];

  acc_gate_rmux #(.DATA_W(DATA_W), .NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_rmux (
    .rd_req_i   (req_i && !we_i),
    .region_i   (region),
    .idx_i      (idx),
    .wperm_i    (wperm),
    .rperm_i    (rperm),
    .tgt_rdata_i(tgt_rdata_i),
    .rdata_o    (rdata_o)
  );

  always_comb begin
    tgt_we_o = '0;
    tgt_re_o = '0;
    if (req_i && region == RGN_TGT) begin
      if (we_i) tgt_we_o[idx] = wperm[idx];
      else      tgt_re_o[idx] = rperm[idx];
    end
  end

  assign tgt_wdata_o = wdata_i;

  p_we_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_we_o));

  p_we_needs_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tgt_we_o) |-> (req_i && we_i));

  p_re_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_re_o));

  p_blocked_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && region == RGN_TGT && !rperm[idx]) |-> (rdata_o == '0));

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (region == RGN_WPERM || region == RGN_RPERM))
      |-> (rdata_o[DATA_W-1:NUM_TGT] == '0));

  p_unmapped_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region == RGN_NONE)
      |-> (rdata_o == '0 && tgt_we_o == '0 && tgt_re_o == '0));
endmodule

// File: tb/acc_gate_tb.sv
`timescale 1ns/1ps
module acc_gate_tb;
  localparam int NT = 8;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req = 1'b0, we = 1'b0;
  logic [11:0]      addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [DW-1:0]    rdata, tgt_wdata;
  logic [NT-1:0]    tgt_we, tgt_re;
  logic [NT*DW-1:0] tgt_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int wp = 8'hFF, rp = 8'hFF; // reference permission state

  always #4 clk = ~clk; // 125 MHz

  acc_gate u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tgt_we_o(tgt_we), .tgt_re_o(tgt_re),
    .tgt_wdata_o(tgt_wdata), .tgt_rdata_i(tgt_rdata)
  );

  function automatic logic [31:0] tval(int i);
    return (32'h1000_0000 * (i + 1)) ^ 32'h00A5_5A00 ^ i;
  endfunction

  initial for (int i = 0; i < NT; i++) tgt_rdata[i*DW +: DW] = tval(i);

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit w, int a, logic [31:0] d, string tg);
    logic [31:0] e_rd;
    logic [7:0]  e_we, e_re;
    @(negedge clk);
    req = r; we = w; addr = a[11:0]; wdata = d;
    #2;
    e_rd = '0; e_we = '0; e_re = '0;
    if (r) begin
      if (a == 'h800 && !w) e_rd = wp;
      if (a == 'h804 && !w) e_rd = rp;
      if (a < NT * 4 && a % 4 == 0) begin
        int i = a / 4;
        if (w) e_we[i] = wp[i];
        else if (rp[i]) begin e_re[i] = 1'b1; e_rd = tval(i); end
      end
    end
    chk(tg, "rdata_o", rdata, e_rd);
    chk(tg, "tgt_we_o", {24'h0, tgt_we}, {24'h0, e_we});
    chk(tg, "tgt_re_o", {24'h0, tgt_re}, {24'h0, e_re});
    if (r && w) chk(tg, "tgt_wdata_o", tgt_wdata, d);
    if (r && w && a == 'h800) wp = wp & d[7:0];
    if (r && w && a == 'h804) rp = rp & d[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0;
    rst_ni = 1'b0;
    #3;
    chk("R1", "rdata_o in reset", rdata, 32'h0);
    wp = 8'hFF; rp = 8'hFF;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset values
    step(1, 0, 'h800, 0, "R1");
    step(1, 0, 'h804, 0, "R1");
    // R6/R8 every target readable, data follows bit order
    for (int i = 0; i < NT; i++) step(1, 0, i * 4, 0, "R6/R8");
    // R5 every target writable
    for (int i = 0; i < NT; i++) step(1, 1, i * 4, 32'hC0DE_0000 + i, "R5");
    // R2 clear seconds and prescaler write bits
    step(1, 1, 'h800, 32'hFFFF_FFFC, "R2");
    step(1, 0, 'h800, 0, "R2");
    step(1, 1, 'h000, 32'h1234, "R5");
    step(1, 1, 'h004, 32'h5678, "R5");
    step(1, 1, 'h008, 32'h9ABC, "R5");
    // R2/R3 ones do not restore
    step(1, 1, 'h800, 32'hFFFF_FFFF, "R3");
    step(1, 0, 'h800, 0, "R3");
    step(0, 0, 0, 0, "R3");
    step(1, 1, 'h004, 32'h1, "R3");
    // R4 upper bits
    step(1, 1, 'h804, 32'hFFFF_FF00 | 8'hFF, "R4");
    step(1, 0, 'h804, 0, "R4");
    // R7 block alarm and status reads
    step(1, 1, 'h804, ~32'h24, "R7");
    for (int i = 0; i < NT; i++) step(1, 0, i * 4, 0, "R7");
    // R9 clear everything; registers stay reachable
    step(1, 1, 'h800, 0, "R9");
    step(1, 1, 'h804, 0, "R9");
    step(1, 0, 'h800, 0, "R9");
    step(1, 0, 'h804, 0, "R9");
    step(1, 1, 'h804, 32'hFF, "R9");
    step(1, 0, 'h804, 0, "R9");
    for (int i = 0; i < NT; i++) step(1, 0, i * 4, 0, "R7");
    for (int i = 0; i < NT; i++) step(1, 1, i * 4, 32'h55, "R5");
    // R10 unmapped and misaligned
    do_reset();
    step(1, 0, 'h020, 0, "R10");
    step(1, 0, 'h802, 0, "R10");
    step(1, 0, 'h001, 0, "R10");
    step(1, 1, 'h006, 32'h0, "R10");
    step(1, 1, 'h801, 32'h0, "R10");
    step(1, 1, 'h7FC, 32'h0, "R10");
    step(1, 0, 'h800, 0, "R10");
    step(1, 0, 'h804, 0, "R10");
    // R3 only reset restores
    step(1, 1, 'h800, 32'h0F, "R3");
    step(1, 1, 'h804, 32'hF0, "R3");
    do_reset();
    step(1, 0, 'h800, 0, "R3");
    step(1, 0, 'h804, 0, "R3");
    step(1, 0, 'h01C, 0, "R3");
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 9);
      int a;
      logic [31:0] d = $urandom;
      if (sel < 6)       a = $urandom_range(0, NT - 1) * 4;
      else if (sel == 6) a = 'h800;
      else if (sel == 7) a = 'h804;
      else               a = $urandom_range(0, 4095);
      if (sel >= 6 && sel <= 7) d = d | 32'hFFFF_FF00 | (32'h1 << $urandom_range(0, 7));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d, "R2/R5/R6/R7");
      if (k % 150 == 149) do_reset();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule